// File: doc/BRIEF.md
# Four-Register Interrupt Unit

This block collects 32 event lines for one unit and reports them to a higher-level interrupt aggregator on a single summary line. A rising edge on an enabled line is latched into a sticky identity register. The summary output is asserted while any latched bit is not blocked by the mask register. Software acknowledges events by writing ones to the identity register. Behind each visible identity bit there is one hidden pending slot, so two events on a line are kept before any further one is lost.

Software reaches four 32-bit registers through a simple single-cycle request port. The request selects a register by word index, which is the byte offset divided by four. The usual enable sequence is: clear any stale identity bits, write the enable register, write the complement of the wanted set into the mask, then read the mask back to post the write. The usual disable sequence is: write all ones to the mask, zero the enable register, then write all ones to the identity register twice to empty both slots.

Top module: `irq_reg_unit`

## Requirements
- R1: The registers are at consecutive word offsets from the unit base. Live status is at +0x0 (index 0), mask at +0x4 (index 1), identity at +0x8 (index 2) and enable at +0xC (index 3). A write changes only the register it selects.
- R2: After reset the mask reads 0xFFFFFFFF, the enable and identity registers read 0, both slots of every bit are empty, and `irq_out` is 0.
- R3: The status register returns the current levels of `evt_in`, and writes to it have no effect.
- R4: The mask register reads back the last value written to it. A 1 in a mask bit keeps the matching identity bit from raising `irq_out`.
- R5: An identity bit is set only by a 0-to-1 transition of its event line that occurs while the matching enable bit is 1. A line held high, or a line whose enable bit is 0, sets nothing.
- R6: Writing a 1 to an identity bit clears it. Writing a 0 leaves it unchanged.
- R7: A second event on a set identity bit waits in that bit's pending slot. The first clear write keeps the bit at 1, and the second clear write empties it. Further events while both slots are full are dropped.
- R8: When an event and a clear write reach the same bit in the same cycle, the event is kept. It goes into the visible slot if that slot is empty after the clear, and otherwise into the pending slot.
- R9: `irq_out` is 1 exactly when some identity bit is 1 and its mask bit is 0.
- R10: The enable register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 32 | Event lines, one per identity bit |
| req_valid | input | 1 | A register access takes place this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_idx | input | 2 | Register word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_out | output | 1 | Summary toward the aggregator |

## Verification
The assertions assume that reset is held low for at least one clock edge. They also assume that every access lasts exactly one cycle, so each `req_valid` pulse stands for exactly one write or read. The bench drives each request and each event level for a single clock period, starting at a falling edge, and it holds reset for several cycles. The assertion on newly set identity bits relies on the pending slot only ever being filled behind a set visible slot. The bench stimulus respects this by reaching the pending slot only through real second events.

// File: rtl/irq_unit_pkg.sv
// Shared definitions for the interrupt register unit.
// Assumes: the register file is addressed by a 2-bit word index.
package irq_unit_pkg;
    typedef enum logic [1:0] {
        RSEL_STATUS = 2'd0,
        RSEL_MASK   = 2'd1,
        RSEL_IDENT  = 2'd2,
        RSEL_ENABLE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
// Rising-edge detector for a vector of event lines.
// Assumes: evt_in is synchronous to clk; a line high when reset ends
// counts as a rising edge.
module irq_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_in,
    output logic [W-1:0] evt_rise
);
    logic [W-1:0] evt_d;

    // Keep the previous level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_d <= '0;
        else        evt_d <= evt_in;
    end

    // A rise is high now and low one cycle ago.
    assign evt_rise = evt_in & ~evt_d;
endmodule

// File: rtl/irq_cfg_regs.sv
// Mask and enable configuration registers.
// Assumes: the write strobes are one-hot or idle; the mask resets to all
// ones and the enable register to zero.
module irq_cfg_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] en_o
);
    // Mask register: a set bit blocks reporting.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '1;
        else if (mask_we) mask_o <= wdata;
    end

    // Enable register: a set bit lets edges latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_o <= '0;
        else if (en_we) en_o <= wdata;
    end
endmodule

// File: rtl/irq_slot_bank.sv
// Two-deep sticky event store per bit: a visible slot and a pending slot.
// Assumes: set_vec is already gated by the enable register. A clear moves
// the pending slot forward before the same-cycle set is applied, so a new
// event is never lost to a clear.
module irq_slot_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] vis_o,
    output logic [W-1:0] pend_o
);
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic vis_q, pend_q, vis_n, pend_n;

        // Next state: apply the clear (promoting the pending slot), then the event.
        always_comb begin
            vis_n  = clr_vec[gi] ? pend_q : vis_q;
            pend_n = clr_vec[gi] ? 1'b0   : pend_q;
            if (set_vec[gi]) begin
                if (!vis_n) vis_n  = 1'b1;
                else        pend_n = 1'b1;
            end
        end

        // Slot registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vis_q  <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                vis_q  <= vis_n;
                pend_q <= pend_n;
            end
        end

        assign vis_o[gi]  = vis_q;
        assign pend_o[gi] = pend_q;
    end
endmodule

// File: rtl/irq_reg_unit.sv
// Per-unit interrupt block: live status, mask, sticky identity with
// write-one-to-clear and a pending slot per bit, and enable.
// Assumes: each request is a single cycle; read data appears the cycle
// after the read request.
module irq_reg_unit
    import irq_unit_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_in,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [1:0]   req_idx,
    input  logic [W-1:0] req_wdata,
    output logic [W-1:0] rsp_rdata,
    output logic         irq_out
);
    logic [W-1:0] evt_rise, mask_q, en_q, ident_q, pend_q, set_vec, clr_vec;
    logic         wr_hit, rd_hit;
    reg_sel_e     sel;

    assign sel    = reg_sel_e'(req_idx);
    assign wr_hit = req_valid &&  req_write;
    assign rd_hit = req_valid && !req_write;

    irq_edge_detect #(.W(W)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_rise(evt_rise)
    );

    irq_cfg_regs #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .mask_we(wr_hit && sel == RSEL_MASK),
        .en_we(wr_hit && sel == RSEL_ENABLE),
        .wdata(req_wdata), .mask_o(mask_q), .en_o(en_q)
    );

    // Only enabled rising edges latch; identity writes clear where 1.
    assign set_vec = evt_rise & en_q;
    assign clr_vec = (wr_hit && sel == RSEL_IDENT) ? req_wdata : '0;

    irq_slot_bank #(.W(W)) u_slots (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .vis_o(ident_q), .pend_o(pend_q)
    );

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_rdata <= '0;
        else if (rd_hit) begin
            case (sel)
                RSEL_STATUS: rsp_rdata <= evt_in;
                RSEL_MASK:   rsp_rdata <= mask_q;
                RSEL_IDENT:  rsp_rdata <= ident_q;
                default:     rsp_rdata <= en_q;
            endcase
        end
    end

    // Summary toward the aggregator.
    assign irq_out = |(ident_q & ~mask_q);
endmodule

// File: rtl/irq_reg_unit_chk.sv
// Checker for irq_reg_unit, attached by bind.
// Assumes: reset is held for at least one edge.
module irq_reg_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_write,
    input logic [1:0]   req_idx,
    input logic [W-1:0] req_wdata,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] en_q,
    input logic [W-1:0] ident_q,
    input logic [W-1:0] pend_q,
    input logic         irq_out
);
    // Reset leaves the unit masked and disabled.
    assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && en_q == '0 && ident_q == '0 && !irq_out));

    // A mask write is held for readback.
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_idx == 2'd1) |=> (mask_q == $past(req_wdata)));

    // A fully set mask silences the summary.
    assert_full_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_out);

    // A newly set identity bit had its enable bit set in the previous cycle.
    assert_enable_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ident_q & ~$past(ident_q) & ~$past(en_q)) == '0));

    // The pending slot is only occupied behind a set visible slot.
    assert_pend_behind_vis_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~ident_q) == '0));

    // An enable write is held for readback.
    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_idx == 2'd3) |=> (en_q == $past(req_wdata)));
endmodule

bind irq_reg_unit irq_reg_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .mask_q(mask_q), .en_q(en_q),
    .ident_q(ident_q), .pend_q(pend_q), .irq_out(irq_out)
);

// File: tb/sim_irq_reg_unit.sv
// Scoreboard bench for irq_reg_unit.
module sim_irq_reg_unit;
    localparam int W = 32;
    localparam logic [1:0] I_STAT = 2'd0, I_MASK = 2'd1, I_IDENT = 2'd2, I_EN = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_in = '0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]   req_idx = '0;
    logic [W-1:0] req_wdata = '0;
    logic [W-1:0] rsp_rdata;
    logic         irq_out;

    int n_run = 0, n_fail = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    bit           done = 1'b0;

    always #2 clk = ~clk;

    irq_reg_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .req_valid(req_valid),
        .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_out(irq_out)
    );

    // Monitor: after each read edge, pop the expected value and compare.
    always begin
        @(posedge clk);
        if (req_valid && !req_write) begin
            #1;
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s read with empty scoreboard, got %h", "R1", rsp_rdata);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s read got %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] idx, input logic [W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_idx = idx; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [W-1:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        req_valid = 1'b1; req_write = 1'b0; req_idx = idx;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse(input logic [W-1:0] b);
        @(negedge clk); evt_in = evt_in | b;
        @(negedge clk); evt_in = evt_in & ~b;
    endtask

    // Same-cycle event rise and identity clear on the given bits.
    task automatic collide(input logic [W-1:0] b);
        @(negedge clk);
        evt_in = evt_in | b;
        req_valid = 1'b1; req_write = 1'b1; req_idx = I_IDENT; req_wdata = b;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; evt_in = evt_in & ~b;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_run++;
        if (irq_out !== e) begin
            n_fail++;
            $display("FAIL %s irq_out got %b expected %b", t, irq_out, e);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset values
        rd(I_STAT, 32'h0, "R2");
        rd(I_MASK, 32'hFFFF_FFFF, "R2");
        rd(I_IDENT, 32'h0, "R2");
        rd(I_EN, 32'h0, "R2");
        chk_irq(1'b0, "R2");
        // R3 live status, writes ignored; R5 edge while disabled is dropped
        @(negedge clk); evt_in = 32'h00F0_0005;
        rd(I_STAT, 32'h00F0_0005, "R3");
        wr(I_STAT, 32'h1234_5678);
        rd(I_STAT, 32'h00F0_0005, "R3");
        @(negedge clk); evt_in = '0;
        rd(I_IDENT, 32'h0, "R5");
        // R10 / R4 readback
        wr(I_EN, 32'h0000_00FF);
        rd(I_EN, 32'h0000_00FF, "R10");
        wr(I_MASK, 32'hFFFF_FFF0);
        rd(I_MASK, 32'hFFFF_FFF0, "R4");
        // R5 enabled edges latch; R9 summary
        pulse(32'h3);
        rd(I_IDENT, 32'h3, "R5");
        chk_irq(1'b1, "R9");
        pulse(32'h100);
        rd(I_IDENT, 32'h3, "R5");
        // R5 held level: one latch only
        @(negedge clk); evt_in = 32'h4;
        @(negedge clk);
        rd(I_IDENT, 32'h7, "R5");
        wr(I_IDENT, 32'h4);
        rd(I_IDENT, 32'h3, "R5");
        @(negedge clk); evt_in = '0;
        // R6 write-one-to-clear
        wr(I_IDENT, 32'h1);
        rd(I_IDENT, 32'h2, "R6");
        // R4 mask blocks; R9 summary
        wr(I_MASK, 32'hFFFF_FFF2);
        chk_irq(1'b0, "R4");
        wr(I_MASK, 32'hFFFF_FFF0);
        chk_irq(1'b1, "R9");
        wr(I_IDENT, 32'h2);
        chk_irq(1'b0, "R9");
        // R7 queue of two
        pulse(32'h10); pulse(32'h10);
        rd(I_IDENT, 32'h10, "R7");
        wr(I_IDENT, 32'h10);
        rd(I_IDENT, 32'h10, "R7");
        wr(I_IDENT, 32'h10);
        rd(I_IDENT, 32'h0, "R7");
        pulse(32'h20); pulse(32'h20); pulse(32'h20);
        wr(I_IDENT, 32'h20);
        rd(I_IDENT, 32'h20, "R7");
        wr(I_IDENT, 32'h20);
        rd(I_IDENT, 32'h0, "R7");
        // R8 collision cases
        collide(32'h40);
        rd(I_IDENT, 32'h40, "R8");
        collide(32'h40);
        rd(I_IDENT, 32'h40, "R8");
        wr(I_IDENT, 32'h40);
        rd(I_IDENT, 32'h0, "R8");
        pulse(32'h80); pulse(32'h80);
        collide(32'h80);
        wr(I_IDENT, 32'h80);
        rd(I_IDENT, 32'h80, "R8");
        wr(I_IDENT, 32'h80);
        rd(I_IDENT, 32'h0, "R8");
        // R1 writes hit only the selected register
        wr(I_EN, 32'hA5A5_0000);
        rd(I_MASK, 32'hFFFF_FFF0, "R1");
        rd(I_EN, 32'hA5A5_0000, "R1");
        rd(I_IDENT, 32'h0, "R1");
        // R5 disabled bit ignores edges
        pulse(32'h1);
        rd(I_IDENT, 32'h0, "R5");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule